// File: doc/BRIEF.md
# Remote CRC-4 Failure Monitor

This block decides whether the far end of an E1 link has a broken CRC-4 multiframe generator or detector. It counts E-bit error strobes over each one-second interval. It also watches two alarm inputs: the received remote-alarm (RAI) bit and the loss-of-basic-frame-alignment status. When an interval closes, the block judges it. The interval qualifies if its E-bit count is above the threshold and neither alarm was seen at any point during it.

The failure status output rises only after five consecutive seconds have qualified. It stays high while later seconds keep qualifying, and it drops on the first second that does not. The one-second tick and the E-bit extraction are supplied from outside the block.

Top module: `rcrc_fail_monitor`

## Requirements
- R1: After reset, `rfail_o` is 0 and the run of qualifying seconds is empty, so five further qualifying seconds are needed before `rfail_o` can rise.
- R2: An interval is made of the cycles after one tick, up to and including the cycle where `sec_tick_i` is next 1. An E-bit strobe in the tick cycle counts toward the interval that is ending. The error count restarts at zero for the next interval.
- R3: An interval qualifies on its error count only if the count is strictly greater than 989. A count of 989 does not qualify and a count of 990 does.
- R4: The error count saturates at 1023 and does not wrap. An interval with more than 1023 strobes still qualifies on its count.
- R5: A 1 on `rai_i` in any cycle of an interval, the tick cycle included, disqualifies that interval.
- R6: A 1 on `sync_loss_i` in any cycle of an interval, the tick cycle included, disqualifies that interval.
- R7: Alarm observations are cleared at every tick. An alarm seen in one interval has no effect on the intervals after it.
- R8: `rfail_o` becomes 1 in the cycle after the tick that ends the fifth qualifying interval in a row. Four qualifying intervals in a row leave it at 0.
- R9: While later intervals keep qualifying, `rfail_o` stays 1. It returns to 0 in the cycle after the tick that ends the first non-qualifying interval.
- R10: `rfail_o` changes only in the cycle that follows a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ebit_err_i | input | 1 | One-cycle strobe for each received E-bit error |
| sec_tick_i | input | 1 | Marks the last cycle of a one-second interval |
| rai_i | input | 1 | Received remote-alarm bit |
| sync_loss_i | input | 1 | 1 while basic frame alignment is lost |
| rfail_o | output | 1 | Remote CRC-4 failure status |

## Verification
Internal state shows at the port only through `rfail_o`, and only one cycle after a tick. Each of the following faults therefore appears within at most five intervals of the stimulus that exposes it:
- an off-by-one in the threshold compare,
- a counter that wraps instead of saturating,
- an alarm latch that misses the tick-cycle sample or fails to clear,
- a run counter that is off by one.

The bench places the fifth interval of a run at error counts just around the threshold. It places single-cycle alarm pulses at the first cycle, the middle cycle and the tick cycle of an interval. It also samples the flag mid-interval to catch any change between ticks.

// File: rtl/rcfm_pkg.sv
package rcfm_pkg;
  localparam int ALARM_N = 2;

  typedef enum logic [0:0] {
    ALM_RAI  = 1'b0,
    ALM_SYNC = 1'b1
  } alarm_idx_e;
endpackage

// File: rtl/ebit_window_counter.sv
module ebit_window_counter #(
  parameter int CNT_W  = 10,
  parameter int THRESH = 989
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_i,
  input  logic tick_i,
  output logic over_o
);
  localparam logic [CNT_W-1:0] MAX_V = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] THR_V = CNT_W'(THRESH);

  logic [CNT_W-1:0] cnt_q, cnt_inc;

  // saturating count including this cycle's strobe
  always_comb begin
    if (cnt_q == MAX_V) cnt_inc = MAX_V;
    else                cnt_inc = cnt_q + CNT_W'(err_i);
  end

  assign over_o = cnt_inc > THR_V;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_i) cnt_q <= '0;
    else             cnt_q <= cnt_inc;
  end

  // R4
  sat_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && cnt_q == MAX_V) |=> cnt_q == MAX_V);

  // R2
  tick_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> cnt_q == '0);
endmodule

// File: rtl/alarm_window_latch.sv
module alarm_window_latch #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] alarm_i,
  input  logic         tick_i,
  output logic         clear_o
);
  logic [N-1:0] seen_q, seen_any;

  for (genvar g = 0; g < N; g++) begin : g_latch
    assign seen_any[g] = seen_q[g] | alarm_i[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     seen_q[g] <= 1'b0;
      else if (tick_i) seen_q[g] <= 1'b0;
      else             seen_q[g] <= seen_any[g];
    end

    // R5 R6
    sticky_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (alarm_i[g] && !tick_i) |=> seen_q[g]);

    // R7
    tick_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tick_i |=> !seen_q[g]);
  end

  assign clear_o = ~|seen_any;
endmodule

// File: rtl/qualify_run_tracker.sv
module qualify_run_tracker #(
  parameter int RUN_LEN = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic qual_i,
  output logic fail_o
);
  localparam int RUN_W = $clog2(RUN_LEN + 1);
  localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(RUN_LEN);

  logic [RUN_W-1:0] run_q, run_d;
  logic             fail_q;

  always_comb begin
    run_d = run_q;
    if (tick_i) begin
      if (!qual_i)                run_d = '0;
      else if (run_q != RUN_MAX)  run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= '0;
      fail_q <= 1'b0;
    end else if (tick_i) begin
      run_q  <= run_d;
      fail_q <= (run_d == RUN_MAX);
    end
  end

  assign fail_o = fail_q;

  // R10
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(fail_q));

  // R9
  bad_second_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !qual_i) |=> !fail_q && run_q == '0);

  // R8
  run_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= RUN_MAX);
endmodule

// File: rtl/rcrc_fail_monitor.sv
module rcrc_fail_monitor #(
  parameter int CNT_W   = 10,
  parameter int THRESH  = 989,
  parameter int RUN_LEN = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ebit_err_i,
  input  logic sec_tick_i,
  input  logic rai_i,
  input  logic sync_loss_i,
  output logic rfail_o
);
  import rcfm_pkg::*;

  logic                over_w, alarm_clear_w, qual_w;
  logic [ALARM_N-1:0]  alarm_w;

  assign alarm_w[ALM_RAI]  = rai_i;
  assign alarm_w[ALM_SYNC] = sync_loss_i;

  ebit_window_counter #(.CNT_W(CNT_W), .THRESH(THRESH)) u_cnt (
    .clk_i(clk_i), .rst_ni(rst_ni), .err_i(ebit_err_i),
    .tick_i(sec_tick_i), .over_o(over_w)
  );

  alarm_window_latch #(.N(ALARM_N)) u_alm (
    .clk_i(clk_i), .rst_ni(rst_ni), .alarm_i(alarm_w),
    .tick_i(sec_tick_i), .clear_o(alarm_clear_w)
  );

  assign qual_w = over_w & alarm_clear_w;

  qualify_run_tracker #(.RUN_LEN(RUN_LEN)) u_run (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(sec_tick_i),
    .qual_i(qual_w), .fail_o(rfail_o)
  );

  // R5
  rai_veto_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick_i && rai_i) |=> !rfail_o);

  // R6
  sync_veto_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sec_tick_i && sync_loss_i) |=> !rfail_o);
endmodule

// File: tb/sim_rcrc_fail_monitor.sv
module sim_rcrc_fail_monitor;
  localparam int SEC_LEN = 1100;
  localparam int THR = 989;
  localparam int SAT = 1023;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic err = 1'b0, tick = 1'b0, rai = 1'b0, syn = 1'b0;
  logic rfail;

  int checks = 0, failures = 0;
  int run_m = 0;
  bit exp_flag = 1'b0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rcrc_fail_monitor u0 (
    .clk_i(clk), .rst_ni(rst_n), .ebit_err_i(err), .sec_tick_i(tick),
    .rai_i(rai), .sync_loss_i(syn), .rfail_o(rfail)
  );

  task automatic chk(input bit act, input bit exp, input string req);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s rfail_o=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // one interval: n_err strobes from cycle 0, optional strobe on tick cycle,
  // one-cycle alarm pulse at the given cycle index (-1 = none)
  task automatic do_second(input int n_err, input bit tick_err, input int rai_at,
                           input int sync_at, input string req);
    int eff;
    bit q;
    for (int c = 0; c < SEC_LEN; c++) begin
      @(negedge clk);
      err  = (c < n_err) || (c == SEC_LEN-1 && tick_err);
      rai  = (c == rai_at);
      syn  = (c == sync_at);
      tick = (c == SEC_LEN-1);
      if (c == SEC_LEN/2) chk(rfail, exp_flag, "R10");
    end
    eff = n_err + (tick_err ? 1 : 0);
    if (eff > SAT) eff = SAT;
    q = (eff > THR) && rai_at < 0 && sync_at < 0;
    if (!q) run_m = 0;
    else if (run_m < 5) run_m++;
    exp_flag = (run_m == 5);
    @(negedge clk);
    err = 0; rai = 0; syn = 0; tick = 0;
    chk(rfail, exp_flag, req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(rfail, 1'b0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk(rfail, 1'b0, "R1");

    // R8: four are not enough, fifth sets
    for (int i = 0; i < 4; i++) do_second(990, 0, -1, -1, "R8");
    do_second(990, 0, -1, -1, "R8");
    // R4: 1099 strobes saturate, still qualifies; R9 flag holds
    do_second(1099, 0, -1, -1, "R4");
    do_second(1050, 0, -1, -1, "R9");
    // R3 / R9: 989 drops the flag
    do_second(989, 0, -1, -1, "R3");

    // R3 sweep around the threshold in the fifth slot
    for (int n = 986; n <= 993; n++) begin
      for (int i = 0; i < 4; i++) do_second(1000, 0, -1, -1, "R8");
      do_second(n, 0, -1, -1, "R3");
      do_second(900, 0, -1, -1, "R9");
    end

    // R2: 989 + strobe on tick cycle qualifies
    for (int i = 0; i < 4; i++) do_second(995, 0, -1, -1, "R8");
    do_second(989, 1, -1, -1, "R2");
    // R2: count restarts, tick-cycle strobe not carried forward
    do_second(989, 0, -1, -1, "R2");

    // R5 / R6 pulses at first, middle and tick cycle of the fifth second
    for (int p = 0; p < 3; p++) begin
      int pos = (p == 0) ? 0 : (p == 1) ? SEC_LEN/2 : SEC_LEN-1;
      for (int i = 0; i < 4; i++) do_second(1000, 0, -1, -1, "R8");
      do_second(1000, 0, pos, -1, "R5");
      for (int i = 0; i < 4; i++) do_second(1000, 0, -1, -1, "R7");
      do_second(1000, 0, -1, pos, "R6");
      // R7: next five clean seconds set the flag again
      for (int i = 0; i < 5; i++) do_second(1000, 0, -1, -1, "R7");
    end

    // R1: reset mid-run clears flag and run
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); chk(rfail, 1'b0, "R1");
    rst_n = 1'b1; run_m = 0; exp_flag = 0;
    for (int i = 0; i < 4; i++) do_second(1000, 0, -1, -1, "R1");
    do_second(1000, 0, -1, -1, "R8");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired, act=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule